// File: doc/BRIEF.md
# Shared 64-bit Timer with Per-Core Comparators

This block is a timer peripheral that a cluster of cores can all see. It holds one free-running 64-bit up-counter. Every core owns a private comparator, a set of control bits, an event flag and an interrupt line. A core raises a one-shot event when the shared count reaches its comparator value. It can instead use a periodic event: the comparator then advances by a programmed step after every match, so events repeat at a fixed spacing while the counter keeps running.

Software reaches the block through a single 32-bit register port. Each access carries the ID of the requesting core. That ID selects which banked copy of the per-core registers is read or written. The shared counter words, the run bit and the prescaler are the same for every core.

Reads are combinational: the data for the presented address and core appears in the same cycle. A write takes effect at the clock edge on which it is presented.

Register words, with byte offsets:

| Offset | Word | Sharing |
|---|---|---|
| 0x00 | Count, low half | Shared |
| 0x04 | Count, high half | Shared |
| 0x08 | Control | Mixed: see R4 |
| 0x0C | Status: event flag in bit 0 | Banked |
| 0x10 | Comparator, low half | Banked |
| 0x14 | Comparator, high half | Banked |
| 0x18 | Step: 32 bits, zero-extended | Banked |

Top module: `shared_tick_timer`

## Requirements
- R1: After reset, every register word reads zero for every core, and all interrupt outputs are low.
- R2: While the run bit (control bit 0, shared by all cores) is set, the counter advances by one once every (P+1) clocks. P is the shared prescaler in control bits [15:8]. The count carries from the low word (offset 0x00) into the high word (offset 0x04).
- R3: Writes to either count word load that half only while the run bit is clear. While the counter runs, such writes are ignored.
- R4: A control write sets the shared run bit and prescaler. It also sets the comparator enable (bit 1), interrupt enable (bit 2) and auto-step enable (bit 3) of the requesting core only. A control read returns the shared fields together with the requesting core's banked bits.
- R5: The comparator words (0x10 low, 0x14 high) and the step word (0x18) are banked by core ID. Writing them for one core leaves every other core's copy unchanged.
- R6: While a core's comparator enable is set, its event flag (status bit 0 at 0x0C) is set by the clock edge at which the registered count is greater than or equal to its comparator. The counter keeps running after a match.
- R7: Writing 1 to status bit 0 clears the requesting core's flag. If a new match occurs on the same edge as the clear, the flag stays set.
- R8: With auto-step off, one comparator value produces at most one match. The core re-arms only when one of its comparator words is written.
- R9: With auto-step on, every match adds the core's step to its 64-bit comparator, and matching stays armed.
- R10: A core's interrupt output is high exactly when its event flag and its interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the 32-bit register word |
| bus_wdata | input | 32 | Write data |
| bus_core | input | CORE_W | ID of the requesting core; selects the banked registers |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | NUM_CORES | Per-core interrupt lines |

## Verification
The hardest case to reach is a match that lands on the same edge as a clear of the flag, because normally a write consumes a cycle the counter keeps running through. The bench forces it by programming a core with auto-step on, a zero step and a comparator of zero. That core then matches on every edge regardless of the count, so any clear write necessarily collides with a match.

Periodic operation is swept cycle by cycle over several step sizes. An arithmetic model in the bench predicts the comparator value and the flag on every cycle.

// File: rtl/stt_pkg.sv
package stt_pkg;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 64;
  localparam int PRESC_W = 8;

  // Word index = byte offset / 4.
  typedef enum logic [2:0] {
    REG_CNT_LO = 3'd0,
    REG_CNT_HI = 3'd1,
    REG_CTRL   = 3'd2,
    REG_STAT   = 3'd3,
    REG_CMP_LO = 3'd4,
    REG_CMP_HI = 3'd5,
    REG_STEP   = 3'd6
  } reg_idx_e;

  localparam int CTL_RUN     = 0;
  localparam int CTL_CMP     = 1;
  localparam int CTL_IRQ     = 2;
  localparam int CTL_AUTO    = 3;
  localparam int CTL_PRE_LSB = 8;

  // Prescaler phase has reached the divide setting.
  function automatic logic tick_due(input logic [PRESC_W-1:0] phase,
                                    input logic [PRESC_W-1:0] div);
    return phase == div;
  endfunction

  // Count has reached or passed the comparator.
  function automatic logic reached(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] cmp);
    return cnt >= cmp;
  endfunction

  // Next comparator value in auto-step mode.
  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0]  cmp,
                                               input logic [WORD_W-1:0] step);
    return cmp + {{(CNT_W-WORD_W){1'b0}}, step};
  endfunction
endpackage

// File: rtl/stt_counter.sv
module stt_counter
  import stt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [PRESC_W-1:0] div,
  input  logic               ld_lo,
  input  logic               ld_hi,
  input  logic [WORD_W-1:0]  ld_data,
  output logic [CNT_W-1:0]   count,
  output logic               tick
);
  logic [PRESC_W-1:0] phase_q;

  assign tick = run && tick_due(phase_q, div);

  // The prescaler phase restarts whenever the counter is stopped.
  always_ff @(posedge clk) begin
    if (!rst_n)            phase_q <= '0;
    else if (!run || tick) phase_q <= '0;
    else                   phase_q <= phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (tick) begin
      count <= count + 1'b1;
    end else if (!run) begin
      if (ld_lo) count[WORD_W-1:0]     <= ld_data;
      if (ld_hi) count[CNT_W-1:WORD_W] <= ld_data;
    end
  end
endmodule

// File: rtl/stt_core_bank.sv
module stt_core_bank
  import stt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic              wr_cmp_lo,
  input  logic              wr_cmp_hi,
  input  logic              wr_step,
  input  logic [WORD_W-1:0] wdata,
  output logic              cmp_en,
  output logic              irq_en,
  output logic              auto_en,
  output logic [CNT_W-1:0]  cmp,
  output logic [WORD_W-1:0] step,
  output logic              flag,
  output logic              hit,
  output logic              clr,
  output logic              cmp_wr,
  output logic              irq
);
  logic armed_q;

  assign cmp_wr = wr_cmp_lo | wr_cmp_hi;
  assign clr    = wr_stat & wdata[0];
  assign hit    = cmp_en & armed_q & reached(cnt, cmp);
  assign irq    = flag & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_en  <= 1'b0;
      irq_en  <= 1'b0;
      auto_en <= 1'b0;
      step    <= '0;
      cmp     <= '0;
    end else begin
      if (wr_ctrl) begin
        cmp_en  <= wdata[CTL_CMP];
        irq_en  <= wdata[CTL_IRQ];
        auto_en <= wdata[CTL_AUTO];
      end
      if (wr_step) step <= wdata;
      // A software write to the comparator takes precedence over auto-step.
      if (cmp_wr) begin
        if (wr_cmp_lo) cmp[WORD_W-1:0]     <= wdata;
        if (wr_cmp_hi) cmp[CNT_W-1:WORD_W] <= wdata;
      end else if (hit && auto_en) begin
        cmp <= advance(cmp, step);
      end
    end
  end

  // Armed: a one-shot match is spent until the comparator is rewritten.
  always_ff @(posedge clk) begin
    if (!rst_n)                armed_q <= 1'b1;
    else if (cmp_wr)           armed_q <= 1'b1;
    else if (hit && !auto_en)  armed_q <= 1'b0;
  end

  // Flag: a new match wins over a clear on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/shared_tick_timer.sv
module shared_tick_timer
  import stt_pkg::*;
#(
  parameter  int NUM_CORES = 4,
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [4:0]           bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  input  logic [CORE_W-1:0]    bus_core,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NUM_CORES-1:0] irq_o
);
  localparam logic [CORE_W:0] CORE_LIMIT = (CORE_W+1)'(NUM_CORES);

  logic [2:0]         idx;
  logic               acc_ok, acc_wr, acc_rd, core_ok;
  logic               count_en_q;
  logic [PRESC_W-1:0] presc_q;
  logic [CNT_W-1:0]   count_q;
  logic               tick_w, cnt_wr_w;

  logic [NUM_CORES-1:0]             hit_w, flag_w, clr_w, cmp_wr_w;
  logic [NUM_CORES-1:0]             cmp_en_w, irq_en_w, auto_w;
  logic [NUM_CORES-1:0][CNT_W-1:0]  cmp_w;
  logic [NUM_CORES-1:0][WORD_W-1:0] step_w;

  assign idx     = bus_addr[4:2];
  assign acc_ok  = bus_sel && (bus_addr[1:0] == 2'b00);
  assign acc_wr  = acc_ok && bus_we;
  assign acc_rd  = acc_ok && !bus_we;
  assign core_ok = {1'b0, bus_core} < CORE_LIMIT;

  // Shared control fields: any core may write them.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_en_q <= 1'b0;
      presc_q    <= '0;
    end else if (acc_wr && core_ok && idx == REG_CTRL) begin
      count_en_q <= bus_wdata[CTL_RUN];
      presc_q    <= bus_wdata[CTL_PRE_LSB +: PRESC_W];
    end
  end

  // Named for the checker: a count-word write that will take effect.
  assign cnt_wr_w = acc_wr && !count_en_q &&
                    (idx == REG_CNT_LO || idx == REG_CNT_HI);

  stt_counter u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (count_en_q),
    .div     (presc_q),
    .ld_lo   (acc_wr && idx == REG_CNT_LO),
    .ld_hi   (acc_wr && idx == REG_CNT_HI),
    .ld_data (bus_wdata),
    .count   (count_q),
    .tick    (tick_w)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic mine;
    assign mine = acc_wr && (bus_core == CORE_W'(g));

    stt_core_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt       (count_q),
      .wr_ctrl   (mine && idx == REG_CTRL),
      .wr_stat   (mine && idx == REG_STAT),
      .wr_cmp_lo (mine && idx == REG_CMP_LO),
      .wr_cmp_hi (mine && idx == REG_CMP_HI),
      .wr_step   (mine && idx == REG_STEP),
      .wdata     (bus_wdata),
      .cmp_en    (cmp_en_w[g]),
      .irq_en    (irq_en_w[g]),
      .auto_en   (auto_w[g]),
      .cmp       (cmp_w[g]),
      .step      (step_w[g]),
      .flag      (flag_w[g]),
      .hit       (hit_w[g]),
      .clr       (clr_w[g]),
      .cmp_wr    (cmp_wr_w[g]),
      .irq       (irq_o[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (acc_rd && core_ok) begin
      case (idx)
        REG_CNT_LO: bus_rdata = count_q[WORD_W-1:0];
        REG_CNT_HI: bus_rdata = count_q[CNT_W-1:WORD_W];
        REG_CTRL: begin
          bus_rdata[CTL_RUN]                  = count_en_q;
          bus_rdata[CTL_CMP]                  = cmp_en_w[bus_core];
          bus_rdata[CTL_IRQ]                  = irq_en_w[bus_core];
          bus_rdata[CTL_AUTO]                 = auto_w[bus_core];
          bus_rdata[CTL_PRE_LSB +: PRESC_W]   = presc_q;
        end
        REG_STAT:   bus_rdata[0] = flag_w[bus_core];
        REG_CMP_LO: bus_rdata = cmp_w[bus_core][WORD_W-1:0];
        REG_CMP_HI: bus_rdata = cmp_w[bus_core][CNT_W-1:WORD_W];
        REG_STEP:   bus_rdata = step_w[bus_core];
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/stt_checker.sv
module stt_checker
  import stt_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             count_en,
  input logic                             tick,
  input logic                             cnt_wr,
  input logic [CNT_W-1:0]                 count,
  input logic [NUM_CORES-1:0]             hit,
  input logic [NUM_CORES-1:0]             flag,
  input logic [NUM_CORES-1:0]             clr,
  input logic [NUM_CORES-1:0]             auto_en,
  input logic [NUM_CORES-1:0]             cmp_wr,
  input logic [NUM_CORES-1:0][CNT_W-1:0]  cmp,
  input logic [NUM_CORES-1:0][WORD_W-1:0] step
);
  assert_tick_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |-> !tick);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == $past(count) + 64'd1);

  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
    assert_hit_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> flag[g]);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[g] && !clr[g]) |=> flag[g]);

    assert_one_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && !auto_en[g] && !cmp_wr[g]) |=> !hit[g]);

    assert_auto_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[g] && auto_en[g] && !cmp_wr[g]) |=>
        cmp[g] == $past(cmp[g]) + {32'd0, $past(step[g])});
  end
endmodule

bind shared_tick_timer stt_checker #(.NUM_CORES(NUM_CORES)) u_stt_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .count_en (count_en_q),
  .tick     (tick_w),
  .cnt_wr   (cnt_wr_w),
  .count    (count_q),
  .hit      (hit_w),
  .flag     (flag_w),
  .clr      (clr_w),
  .auto_en  (auto_w),
  .cmp_wr   (cmp_wr_w),
  .cmp      (cmp_w),
  .step     (step_w)
);

// File: tb/tb_shared_tick_timer.sv
`timescale 1ns/100ps
module tb_shared_tick_timer;
  localparam int NC = 4;
  localparam int A_LO = 0, A_HI = 4, A_CTRL = 8, A_STAT = 12;
  localparam int A_CMPL = 16, A_CMPH = 20, A_STEP = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_core = '0;
  logic [31:0] bus_rdata;
  logic [NC-1:0] irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  shared_tick_timer #(.NUM_CORES(NC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_core(bus_core),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Write takes effect at the posedge; returns 1 ns after it.
  task automatic wr(input int core, input int addr, input logic [31:0] d);
    @(negedge clk);
    bus_core = 2'(core); bus_addr = 5'(addr); bus_wdata = d;
    bus_we = 1'b1; bus_sel = 1'b1;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int core, input int addr, output logic [31:0] d);
    bus_core = 2'(core); bus_addr = 5'(addr); bus_we = 1'b0; bus_sel = 1'b1;
    #0.5;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    logic [63:0] mc;
    logic        mf;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    for (int c = 0; c < NC; c++)
      for (int a = 0; a <= 24; a += 4) begin
        rd(c, a, v);
        chk("R1 reset word", 64'(v), 64'd0);
      end
    chk("R1 irq reset", 64'(irq_o), 64'd0);

    // R2/R3/R4: prescaler sweep, load while stopped, carry into high word
    for (int p = 0; p < 6; p++) begin
      wr(0, A_CTRL, 32'(p) << 8);
      rd(0, A_CTRL, v);
      chk("R4 ctrl prescaler readback", 64'(v), 64'(p) << 8);
      wr(0, A_LO, 32'hFFFF_FFF0);
      wr(0, A_HI, 32'(p));
      rd(0, A_LO, v); rd(0, A_HI, v2);
      chk("R3 load while stopped", {v2, v}, {32'(p), 32'hFFFF_FFF0});
      wr(0, A_CTRL, (32'(p) << 8) | 32'd1);
      repeat (39) @(posedge clk);
      wr(0, A_CTRL, 32'(p) << 8);
      rd(0, A_LO, v); rd(0, A_HI, v2);
      chk("R2 count after 40 clocks", {v2, v},
          {32'(p), 32'hFFFF_FFF0} + 64'(40 / (p + 1)));
    end

    // R3: write while running is ignored
    wr(0, A_CTRL, 32'd0);
    wr(0, A_LO, 32'd100);
    wr(0, A_HI, 32'd0);
    wr(0, A_CTRL, 32'd1);
    wr(0, A_LO, 32'h1234);
    wr(0, A_CTRL, 32'd0);
    rd(0, A_LO, v);
    chk("R3 write while running ignored", 64'(v), 64'd102);

    // R6/R10: one-shot match on core1
    wr(0, A_LO, 32'd0);
    wr(1, A_CMPL, 32'd20);
    wr(1, A_CMPH, 32'd0);
    wr(1, A_CTRL, 32'h6);
    wr(0, A_CTRL, 32'd1);
    repeat (20) @(posedge clk);
    #1;
    rd(1, A_STAT, v);
    chk("R6 no flag before match", 64'(v), 64'd0);
    chk("R10 irq low before match", 64'(irq_o[1]), 64'd0);
    @(posedge clk); #1;
    rd(1, A_STAT, v); rd(0, A_LO, v2);
    chk("R6 flag at match", 64'(v), 64'd1);
    chk("R6 counter keeps running", 64'(v2), 64'd21);
    chk("R10 irq core1 high", 64'(irq_o[1]), 64'd1);
    chk("R4 core0 unaffected", 64'(irq_o[0]), 64'd0);
    rd(0, A_STAT, v);
    chk("R4 core0 flag banked", 64'(v), 64'd0);

    // R7/R8: clear, no refire, re-arm by comparator write
    wr(1, A_STAT, 32'd1);
    rd(1, A_STAT, v);
    chk("R7 clear", 64'(v), 64'd0);
    repeat (5) @(posedge clk);
    #1;
    rd(1, A_STAT, v);
    chk("R8 no second match", 64'(v), 64'd0);
    chk("R10 irq low after clear", 64'(irq_o[1]), 64'd0);
    wr(1, A_CMPL, 32'd20);
    rd(1, A_STAT, v);
    chk("R8 rearm not yet visible", 64'(v), 64'd0);
    @(posedge clk); #1;
    rd(1, A_STAT, v);
    chk("R8 rearm fires", 64'(v), 64'd1);

    // R10/R4: interrupt enable gating
    wr(1, A_CTRL, 32'h3);
    chk("R10 irq masked", 64'(irq_o[1]), 64'd0);
    rd(1, A_STAT, v);
    chk("R10 flag still set", 64'(v), 64'd1);
    wr(1, A_CTRL, 32'h7);
    chk("R10 irq unmasked", 64'(irq_o[1]), 64'd1);
    rd(1, A_CTRL, v);
    chk("R4 core1 ctrl", 64'(v), 64'h7);
    rd(0, A_CTRL, v);
    chk("R4 core0 ctrl shared run", 64'(v), 64'h1);

    // R5: banking of comparator and step
    rd(0, A_CMPL, v);
    chk("R5 core0 comparator", 64'(v), 64'd0);
    rd(1, A_CMPL, v);
    chk("R5 core1 comparator", 64'(v), 64'd20);
    wr(3, A_STEP, 32'd9);
    rd(1, A_STEP, v);
    chk("R5 core1 step untouched", 64'(v), 64'd0);
    rd(3, A_STEP, v);
    chk("R5 core3 step", 64'(v), 64'd9);

    // R9: auto-step sweep on core2
    foreach (stp_list[i]) begin end
    for (int s = 1; s <= 5; s += 2) begin
      wr(0, A_CTRL, 32'd0);
      wr(0, A_LO, 32'd0);
      wr(0, A_HI, 32'd0);
      wr(2, A_CMPH, 32'd0);
      wr(2, A_CMPL, 32'd3);
      wr(2, A_STEP, 32'(s));
      wr(2, A_CTRL, 32'hE);
      wr(2, A_STAT, 32'd1);
      wr(0, A_CTRL, 32'd1);
      mc = 64'd3; mf = 1'b0;
      for (int j = 1; j <= 40; j++) begin
        @(posedge clk);
        if (64'(j - 1) >= mc) begin mc = mc + 64'(s); mf = 1'b1; end
        #1;
        rd(2, A_CMPL, v);
        chk("R9 comparator advance", 64'(v), mc);
        rd(2, A_STAT, v);
        chk("R9 periodic flag", 64'(v), 64'(mf));
        rd(0, A_LO, v);
        chk("R2 count per cycle", 64'(v), 64'(j));
      end
    end

    // R7: match on the same edge as clear keeps the flag
    wr(0, A_CTRL, 32'd0);
    wr(3, A_CMPL, 32'd0);
    wr(3, A_CMPH, 32'd0);
    wr(3, A_STEP, 32'd0);
    wr(3, A_CTRL, 32'hA);
    wr(3, A_STAT, 32'd1);
    rd(3, A_STAT, v);
    chk("R7 match wins over clear", 64'(v), 64'd1);
    chk("R10 irq off when disabled", 64'(irq_o[3]), 64'd0);
    wr(3, A_CTRL, 32'd0);
    wr(3, A_STAT, 32'd1);
    rd(3, A_STAT, v);
    chk("R7 clear without match", 64'(v), 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  int stp_list[1] = '{0};
endmodule